// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the register-level interrupt and status state of a flash controller. It keeps three registers: a controller status register with four error flags, an interrupt status register with a master flag and four completion events, and a system configuration register. A single register write port reaches the configuration, interrupt and command registers. A registered read port returns any of the four registers.

A command write passes a gate. It is dropped while the master interrupt flag is pending. Otherwise the command is latched, and a known code is handed to the command engine as a one-cycle issue strobe. Two codes reset the flash core, and any code that is not recognised raises a command error.

The command engine reports completion through a one-cycle done strobe that carries event flags and error flags. The interrupt pin is the master flag XORed with the inverse of a polarity bit in the configuration register. The ready pin follows a configuration bit. Both pins are registered.

Top module: `flsc_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the configuration register is 0x40C0, the status register is 0x0000, the interrupt register is 0x8080, `irq` is 1 and `ready` is 1.
- R2: A one-cycle pulse on `warm_rst` sets the interrupt register to 0x8010, the configuration register to 0x40C0 and the status and command registers to 0.
- R3: A command write (`wr_sel`=2) made while interrupt bit 15 is set is dropped. The command register keeps its value and `cmd_issue` stays low.
- R4: An accepted command write of a known code latches the value into the command register. `cmd_issue` is then high for exactly the following cycle, with `cmd_code` equal to the value. The known codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30 and 0x65.
- R5: An accepted command write of an unknown code sets status bit 10 (command error) and interrupt bit 15, and raises no `cmd_issue`.
- R6: An accepted command write of 0xF0 or 0xF3 performs the warm reset of R2 and raises no `cmd_issue`.
- R7: A write to the interrupt register (`wr_sel`=1) ANDs the written value into the register.
- R8: If interrupt bit 15 is clear after that AND, status bits 13:10 are cleared. If bit 15 stays set, they are kept.
- R9: A `done_vld` cycle ORs `done_evt[3:0]` into interrupt bits 7:4 (reset, erase, program, load), ORs `done_err[3:0]` into status bits 13:10 (command, erase, program, load error), and sets interrupt bit 15.
- R10: `irq` equals interrupt bit 15 XOR the inverse of configuration bit 6. It takes the register values of the previous cycle.
- R11: `ready` equals configuration bit 7 of the previous cycle.
- R12: A configuration write (`wr_sel`=0) stores all 16 bits. A configuration read returns them with bits 4:0 forced to zero.
- R13: A write with `wr_sel`=3 (status) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 interrupt, 2 command, 3 status (ignored) |
| wr_data | input | 16 | Write value |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read target: 0 config, 1 interrupt, 2 command, 3 status |
| rd_data | output | 16 | Registered read value, valid the cycle after `rd_en` |
| done_vld | input | 1 | Completion strobe from the command engine |
| done_evt | input | 4 | Completion events: reset, erase, program, load |
| done_err | input | 4 | Errors: command, erase, program, load |
| irq | output | 1 | Interrupt pin |
| ready | output | 1 | Ready pin |
| cmd_issue | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 16 | Latched command value |

## Verification
The bench issues a command while the master flag is still set from reset, and checks that the command register does not move. A design that gates on the wrong bit, or not at all, would latch the command and issue it. It clears the interrupt register once with bit 15 kept and once with bit 15 dropped. A design that wipes the error flags on any interrupt write, or never wipes them, shows the wrong status. It also checks the one-cycle lag of `irq` and `ready` against the pin polarity bit, since an unregistered or wrongly inverted pin would flip a cycle early or to the wrong level. Finally, it checks that the reset codes and unknown codes produce no issue strobe.

// File: rtl/flsc_pkg.sv
package flsc_pkg;
  localparam int REG_W       = 16;
  localparam int NUM_FLAG    = 4;
  localparam int INT_MASTER  = 15;
  localparam int INT_EVT_LO  = 4;
  localparam int STAT_ERR_LO = 10;
  localparam int CFG_POL_BIT = 6;
  localparam int CFG_RDY_BIT = 7;
  localparam int CFG_RD_MASK_W = 5;

  localparam logic [REG_W-1:0] CFG_RST_VAL  = 16'h40C0;
  localparam logic [REG_W-1:0] INT_COLD_VAL = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM_VAL = 16'h8010;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_INT  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CK_ISSUE = 2'd0,
    CK_CORE_RST = 2'd1,
    CK_BAD = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e classify_cmd(input logic [REG_W-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065:
        return CK_ISSUE;
      16'h00F0, 16'h00F3:
        return CK_CORE_RST;
      default:
        return CK_BAD;
    endcase
  endfunction
endpackage

// File: rtl/flsc_cmd_gate.sv
module flsc_cmd_gate
  import flsc_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         wr_cmd,
  input  logic [W-1:0] cmd_val,
  input  logic         master_pend,
  output logic         accept,
  output logic         issue_req,
  output logic         core_rst,
  output logic         bad_cmd
);
  cmd_kind_e kind;

  always_comb begin
    kind      = classify_cmd(cmd_val);
    accept    = wr_cmd && !master_pend;
    issue_req = accept && (kind == CK_ISSUE);
    core_rst  = accept && (kind == CK_CORE_RST);
    bad_cmd   = accept && (kind == CK_BAD);
  end
endmodule

// File: rtl/flsc_irq_regs.sv
module flsc_irq_regs
  import flsc_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NF = NUM_FLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm,
  input  logic          wr_int,
  input  logic [W-1:0]  wr_data,
  input  logic          done_vld,
  input  logic [NF-1:0] done_evt,
  input  logic [NF-1:0] done_err,
  input  logic          bad_cmd,
  output logic [W-1:0]  int_q,
  output logic [W-1:0]  stat_q
);
  logic [W-1:0] int_d, stat_d;

  always_comb begin
    int_d  = int_q;
    stat_d = stat_q;
    if (wr_int) begin
      int_d = int_q & wr_data;
      if (!int_d[INT_MASTER])
        stat_d[STAT_ERR_LO +: NF] = '0;
    end
    if (bad_cmd) begin
      stat_d[STAT_ERR_LO] = 1'b1;
      int_d[INT_MASTER]   = 1'b1;
    end
    if (done_vld) begin
      int_d[INT_MASTER]         = 1'b1;
      int_d[INT_EVT_LO +: NF]   = int_d[INT_EVT_LO +: NF] | done_evt;
      stat_d[STAT_ERR_LO +: NF] = stat_d[STAT_ERR_LO +: NF] | done_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= INT_COLD_VAL;
      stat_q <= '0;
    end else if (warm) begin
      int_q  <= INT_WARM_VAL;
      stat_q <= '0;
    end else begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/flsc_cfg_pins.sv
module flsc_cfg_pins
  import flsc_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm,
  input  logic         wr_cfg,
  input  logic [W-1:0] wr_data,
  input  logic         int_master,
  output logic [W-1:0] cfg_q,
  output logic         irq,
  output logic         ready
);
  always_ff @(posedge clk) begin
    if (rst || warm)
      cfg_q <= CFG_RST_VAL;
    else if (wr_cfg)
      cfg_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b1;
      ready <= 1'b1;
    end else begin
      irq   <= int_master ^ ~cfg_q[CFG_POL_BIT];
      ready <= cfg_q[CFG_RDY_BIT];
    end
  end
endmodule

// File: rtl/flsc_ctrl.sv
module flsc_ctrl
  import flsc_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NF = NUM_FLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [W-1:0]  rd_data,
  input  logic          done_vld,
  input  logic [NF-1:0] done_evt,
  input  logic [NF-1:0] done_err,
  output logic          irq,
  output logic          ready,
  output logic          cmd_issue,
  output logic [W-1:0]  cmd_code
);
  localparam logic [W-1:0] CFG_RD_MASK = ~W'((1 << CFG_RD_MASK_W) - 1);

  logic [W-1:0] int_reg, stat_reg, cfg_reg, cmd_reg;
  logic accept, issue_req, core_rst, bad_cmd, warm;
  logic wr_cmd, wr_int, wr_cfg;

  assign wr_cmd = wr_en && (wr_sel == SEL_CMD);
  assign wr_int = wr_en && (wr_sel == SEL_INT);
  assign wr_cfg = wr_en && (wr_sel == SEL_CFG);
  assign warm   = warm_rst || core_rst;

  flsc_cmd_gate #(.W(W)) u_gate (
    .wr_cmd(wr_cmd), .cmd_val(wr_data), .master_pend(int_reg[INT_MASTER]),
    .accept(accept), .issue_req(issue_req), .core_rst(core_rst), .bad_cmd(bad_cmd)
  );

  flsc_irq_regs #(.W(W), .NF(NF)) u_regs (
    .clk(clk), .rst(rst), .warm(warm), .wr_int(wr_int), .wr_data(wr_data),
    .done_vld(done_vld), .done_evt(done_evt), .done_err(done_err),
    .bad_cmd(bad_cmd), .int_q(int_reg), .stat_q(stat_reg)
  );

  flsc_cfg_pins #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .warm(warm), .wr_cfg(wr_cfg), .wr_data(wr_data),
    .int_master(int_reg[INT_MASTER]), .cfg_q(cfg_reg), .irq(irq), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (rst || warm) begin
      cmd_reg   <= '0;
      cmd_issue <= 1'b0;
    end else begin
      cmd_issue <= issue_req;
      if (accept)
        cmd_reg <= wr_data;
    end
  end

  assign cmd_code = cmd_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_sel)
        SEL_CFG: rd_data <= cfg_reg & CFG_RD_MASK;
        SEL_INT: rd_data <= int_reg;
        SEL_CMD: rd_data <= cmd_reg;
        default: rd_data <= stat_reg;
      endcase
    end
  end
endmodule

// File: rtl/flsc_checker.sv
module flsc_checker
  import flsc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        warm_rst,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic        done_vld,
  input logic        irq,
  input logic        ready,
  input logic        cmd_issue,
  input logic [15:0] int_reg,
  input logic [15:0] stat_reg,
  input logic [15:0] cfg_reg
);
  AST_CMD_GATED: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (wr_en && wr_sel == SEL_CMD && int_reg[INT_MASTER]) |=> !cmd_issue); // R3

  AST_BAD_CMD_FLAGS: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (wr_en && wr_sel == SEL_CMD && !int_reg[INT_MASTER] && classify_cmd(wr_data) == CK_BAD)
    |=> (int_reg[INT_MASTER] && stat_reg[STAT_ERR_LO] && !cmd_issue)); // R5

  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (wr_en && wr_sel == SEL_INT && !wr_data[INT_MASTER] && !done_vld)
    |=> (stat_reg[STAT_ERR_LO +: NUM_FLAG] == '0)); // R8

  AST_DONE_MASTER: assert property (@(posedge clk) disable iff (rst)
    done_vld |=> int_reg[INT_MASTER]); // R9

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(int_reg[INT_MASTER]) ^ ~$past(cfg_reg[CFG_POL_BIT])))); // R10

  AST_READY_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ready == $past(cfg_reg[CFG_RDY_BIT]))); // R11
endmodule

bind flsc_ctrl flsc_checker u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .done_vld(done_vld), .irq(irq), .ready(ready),
  .cmd_issue(cmd_issue), .int_reg(int_reg), .stat_reg(stat_reg), .cfg_reg(cfg_reg)
);

// File: tb/tb_flsc_ctrl.sv
module tb_flsc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        done_vld = 1'b0;
  logic [3:0]  done_evt = '0;
  logic [3:0]  done_err = '0;
  logic        irq, ready, cmd_issue;
  logic [15:0] cmd_code;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flsc_ctrl dut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .done_vld(done_vld), .done_evt(done_evt), .done_err(done_err),
    .irq(irq), .ready(ready), .cmd_issue(cmd_issue), .cmd_code(cmd_code)
  );

  // vector: kind[39:38] sel[37:36] data[35:20] exp[19:4] req[3:0]
  // kind 0 = write, 1 = done (data[7:4] err, data[3:0] evt), 2 = read-compare
  localparam int NV = 27;
  localparam logic [39:0] VEC [NV] = '{
    {2'd2, 2'd1, 16'h0000, 16'h8080, 4'd1},  // R1 interrupt after cold reset
    {2'd2, 2'd0, 16'h0000, 16'h40C0, 4'd1},  // R1 config
    {2'd2, 2'd3, 16'h0000, 16'h0000, 4'd1},  // R1 status
    {2'd0, 2'd2, 16'h0080, 16'h0000, 4'd0},  // command while master set
    {2'd2, 2'd2, 16'h0000, 16'h0000, 4'd3},  // R3 dropped
    {2'd0, 2'd1, 16'h7FFF, 16'h0000, 4'd0},
    {2'd2, 2'd1, 16'h0000, 16'h0080, 4'd7},  // R7 AND mask
    {2'd0, 2'd2, 16'h0080, 16'h0000, 4'd0},
    {2'd2, 2'd2, 16'h0000, 16'h0080, 4'd4},  // R4 latched
    {2'd1, 2'd0, 16'h0048, 16'h0000, 4'd0},  // done: load event, program error
    {2'd2, 2'd1, 16'h0000, 16'h8080, 4'd9},  // R9
    {2'd2, 2'd3, 16'h0000, 16'h1000, 4'd9},  // R9
    {2'd0, 2'd1, 16'hFF7F, 16'h0000, 4'd0},
    {2'd2, 2'd1, 16'h0000, 16'h8000, 4'd7},  // R7
    {2'd2, 2'd3, 16'h0000, 16'h1000, 4'd8},  // R8 kept while master set
    {2'd0, 2'd1, 16'h0000, 16'h0000, 4'd0},
    {2'd2, 2'd3, 16'h0000, 16'h0000, 4'd8},  // R8 wiped
    {2'd0, 2'd2, 16'h00AB, 16'h0000, 4'd0},
    {2'd2, 2'd3, 16'h0000, 16'h0400, 4'd5},  // R5
    {2'd2, 2'd1, 16'h0000, 16'h8000, 4'd5},  // R5
    {2'd0, 2'd3, 16'hFFFF, 16'h0000, 4'd0},
    {2'd2, 2'd3, 16'h0000, 16'h0400, 4'd13}, // R13
    {2'd0, 2'd0, 16'h00FF, 16'h0000, 4'd0},
    {2'd2, 2'd0, 16'h0000, 16'h00E0, 4'd12}, // R12
    {2'd0, 2'd1, 16'h0000, 16'h0000, 4'd0},
    {2'd0, 2'd2, 16'h00F0, 16'h0000, 4'd0},
    {2'd2, 2'd1, 16'h0000, 16'h8010, 4'd6}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {15'd0, irq}, 16'd1);
    check("R1 ready", {15'd0, ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][39:38])
        2'd0: do_write(VEC[i][37:36], VEC[i][35:20]);
        2'd1: begin
          @(negedge clk);
          done_vld = 1'b1; done_err = VEC[i][27:24]; done_evt = VEC[i][23:20];
          @(negedge clk);
          done_vld = 1'b0; done_err = '0; done_evt = '0;
        end
        default: begin
          do_read(VEC[i][37:36], v);
          check($sformatf("R%0d vec %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
        end
      endcase
    end

    // R6: reset command raised no issue strobe
    check("R6 no issue", {15'd0, cmd_issue}, 16'd0);

    // R10: irq lags one cycle (int=8010, cfg6=1 -> irq 1)
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 irq before lag", {15'd0, irq}, 16'd1);
    @(negedge clk);
    check("R10 irq after clear", {15'd0, irq}, 16'd0);

    // R10/R11: config 0x0000 flips polarity and drops ready
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 ready lag", {15'd0, ready}, 16'd1);
    @(negedge clk);
    check("R11 ready low", {15'd0, ready}, 16'd0);
    check("R10 polarity", {15'd0, irq}, 16'd1);

    // R4: issue strobe for one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0094;
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 issue", {15'd0, cmd_issue}, 16'd1);
    check("R4 code", cmd_code, 16'h0094);
    @(negedge clk);
    check("R4 single pulse", {15'd0, cmd_issue}, 16'd0);

    // R6: 0xF3 acts as core reset
    do_write(2'd2, 16'h00F3);
    check("R6 no issue F3", {15'd0, cmd_issue}, 16'd0);
    do_read(2'd1, v);
    check("R6 int F3", v, 16'h8010);
    do_read(2'd0, v);
    check("R6 cfg F3", v, 16'h40C0);

    // R2: warm reset pin
    do_write(2'd1, 16'h0000);
    do_write(2'd0, 16'h1234);
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    do_read(2'd1, v);
    check("R2 int", v, 16'h8010);
    do_read(2'd0, v);
    check("R2 cfg", v, 16'h40C0);
    do_read(2'd2, v);
    check("R2 cmd", v, 16'h0000);

    // R1: cold reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_read(2'd1, v);
    check("R1 int again", v, 16'h8080);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule